// File: doc/BRIEF.md
# Serial Peripheral Master Frame Sequencer (clock idle high, second-edge launch)

This block is the transmit and receive engine of a serial-peripheral master, fixed to one framing mode. The serial clock rests high. Receive bits are captured on its falling edges, and transmit bits change on its rising edges. Words come in over a valid/ready handshake that sits in front of a transmit queue. Each word is shifted out most significant bit first with a programmable length of 4 to 16 bits. Each word received at the same time is returned right-aligned, with a one-cycle valid strobe.

Each frame starts by dropping the active-low frame select and the active-low transmit-pad enable together. After half a serial-clock period the first bit appears on the transmit line. After one more half period the clock makes its first falling edge. All steps are timed by a half-period tick of (DIV+1) system clock cycles, written H below. When another word is waiting at the end of a frame, frame select is raised for one full serial period and then lowered again for the next word. The clock-pad enable is held active, because the block always drives the clock.

Top module: `spi_frame_master`

## Requirements
- R1: With no frame in progress, sclk is 1, fss_n is 1, txd is 0 and data_oe_n is 1.
- R2: clk_oe_n is 0 at all times, including during reset.
- R3: A word is taken only in a cycle where enable, tx_valid and tx_ready are all 1. When enable is 0, tx_ready stays 0 and no frame starts.
- R4: fss_n and data_oe_n go low in the same cycle. During the first H cycles of the frame, txd stays 0 and sclk stays 1.
- R5: H cycles after fss_n falls, txd carries the most significant bit of the word.
- R6: The first falling edge of sclk comes 2H cycles after fss_n falls, where H = DIV+1.
- R7: A frame of W bits has exactly W falling edges of sclk. The txd values seen at those falling edges, in order, are word bits W-1 down to 0.
- R8: word_len is latched when the word is accepted. Values below 4 act as 4 and values above 16 act as 16. Bits of tx_data above the effective length are never sent.
- R9: When no word is pending, fss_n rises 2H cycles after the last falling edge of sclk. This makes the whole frame (2W+2)H cycles long.
- R10: When the next word is accepted at the end of a frame, fss_n stays high for exactly 2H cycles with sclk high, and then falls for that word.
- R11: rx_valid is a one-cycle pulse that appears in the cycle the last bit is captured. rx_data holds the captured bits in order, right-aligned, with unused upper bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allows new frames to start |
| word_len | input | 5 | Bits per word, 4..16, clamped |
| tx_data | input | 16 | Word to send, right-aligned |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Word is taken this cycle if tx_valid |
| rx_data | output | 16 | Received word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| sclk | output | 1 | Serial clock, idle high |
| fss_n | output | 1 | Frame select, active low |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |
| data_oe_n | output | 1 | Transmit pad enable, active low |
| clk_oe_n | output | 1 | Clock pad enable, active low |

## Verification
The end of a frame's tail half period and the acceptance of the next word can fall in the same clock cycle. One tick must then raise frame select, reload the shift register and start the gap. The bench provokes this by offering the next word while the current frame is still running, both in a directed run of three words and in random runs. It judges the result by the length of the high pulse on fss_n and by the bit order and bit count of the following frame.

// File: rtl/spi_frame_master.sv
module spi_frame_master #(
  parameter int DIV  = 2,
  parameter int MAXW = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enable,
  input  logic [$clog2(MAXW+1)-1:0]  word_len,
  input  logic [MAXW-1:0]            tx_data,
  input  logic                       tx_valid,
  output logic                       tx_ready,
  output logic [MAXW-1:0]            rx_data,
  output logic                       rx_valid,
  output logic                       sclk,
  output logic                       fss_n,
  output logic                       txd,
  input  logic                       rxd,
  output logic                       data_oe_n,
  output logic                       clk_oe_n
);
  localparam int LW = $clog2(MAXW+1);
  localparam int CW = $clog2(DIV+2);

  typedef enum logic [2:0] {IDLE, LEAD, SHIFT, TAIL, GAP} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic           ph;
  logic [LW-1:0]  bits;
  logic [MAXW-1:0] tsh, rsh;
  logic [LW-1:0]  weff;
  logic           tick, take;

  assign weff = (word_len < LW'(4)) ? LW'(4) :
                (word_len > LW'(MAXW)) ? LW'(MAXW) : word_len;
  assign tick = (cnt == CW'(DIV));
  assign tx_ready = enable && (st == IDLE || (st == TAIL && tick));
  assign take = tx_ready && tx_valid;

  assign sclk      = !(st == SHIFT && ph);
  assign fss_n     = (st == IDLE) || (st == GAP);
  assign data_oe_n = (st == IDLE);
  assign txd       = (st == SHIFT || st == TAIL) ? tsh[MAXW-1] : 1'b0;
  assign clk_oe_n  = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      cnt      <= '0;
      ph       <= 1'b0;
      bits     <= '0;
      tsh      <= '0;
      rsh      <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      cnt <= (st == IDLE || tick) ? '0 : cnt + 1'b1;
      case (st)
        IDLE: if (take) begin
          st   <= LEAD;
          tsh  <= tx_data << (LW'(MAXW) - weff);
          rsh  <= '0;
          bits <= weff;
        end
        LEAD: if (tick) begin
          st <= SHIFT;
          ph <= 1'b0;
        end
        SHIFT: if (tick) begin
          if (!ph) begin
            ph  <= 1'b1;
            rsh <= {rsh[MAXW-2:0], rxd};
            if (bits == LW'(1)) begin
              rx_valid <= 1'b1;
              rx_data  <= {rsh[MAXW-2:0], rxd};
            end
          end else begin
            ph <= 1'b0;
            if (bits == LW'(1)) st <= TAIL;
            else begin
              tsh  <= tsh << 1;
              bits <= bits - 1'b1;
            end
          end
        end
        TAIL: if (tick) begin
          if (take) begin
            st   <= GAP;
            ph   <= 1'b0;
            tsh  <= tx_data << (LW'(MAXW) - weff);
            rsh  <= '0;
            bits <= weff;
          end else st <= IDLE;
        end
        GAP: if (tick) begin
          if (ph) st <= LEAD;
          ph <= ~ph;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module spi_frame_master_chk #(
  parameter int MAXW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            enable,
  input logic            tx_ready,
  input logic            rx_valid,
  input logic [MAXW-1:0] rx_data,
  input logic            sclk,
  input logic            fss_n,
  input logic            txd,
  input logic            data_oe_n
);
  // R1
  idle_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe_n |-> (sclk && fss_n && !txd));
  // R4
  frame_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fss_n |-> !data_oe_n);
  // R10
  clk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk |-> !fss_n);
  // R3
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> enable);
  // R11
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R7
  txd_hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk && !$past(sclk)) |-> $stable(txd));
  // R11
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_data));
endmodule

bind spi_frame_master spi_frame_master_chk #(.MAXW(MAXW)) u_chk (.*);

// File: tb/test_spi_frame_master.sv
module test_spi_frame_master;
  localparam int DIV = 2;
  localparam int H = DIV + 1;

  logic clk = 0, rst_n = 0, enable = 0, tx_valid = 0, rxd = 0;
  logic [4:0] word_len = 5'd8;
  logic [15:0] tx_data = '0;
  logic tx_ready, rx_valid, sclk, fss_n, txd, data_oe_n, clk_oe_n;
  logic [15:0] rx_data;

  spi_frame_master #(.DIV(DIV)) i_spi_frame_master (.*);

  always #10 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;
  int exp_w[$], exp_len[$], rx_exp[$];
  int gaps[$];
  logic [15:0] sw, got;
  int slen = 4, bitn = 0, nfall = 0;
  int fall_cyc = 0, first_fall = 0, last_fall = 0, rise_cyc = 0;
  bit inframe = 0, had_rise = 0;

  always @(posedge clk) cyc++;

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int eff(int l);
    return (l < 4) ? 4 : (l > 16) ? 16 : l;
  endfunction

  function automatic int msk(int l);
    return (1 << l) - 1;
  endfunction

  // slave model and frame-start timing (R4, R5)
  always @(negedge fss_n) if (rst_n) begin
    inframe = 1;
    if (had_rise) gaps.push_back(cyc - rise_cyc);
    fall_cyc = cyc;
    nfall = 0;
    got = '0;
    bitn = 0;
    slen = (exp_len.size() > 0) ? exp_len[0] : 4;
    sw = 16'($urandom) & 16'(msk(slen));
    rx_exp.push_back(int'(sw));
    rxd <= sw[slen-1];
    @(negedge clk);
    chk(txd == 0 && sclk && !data_oe_n, "R4", {txd, sclk, data_oe_n}, 3'b010);
    repeat (H) @(posedge clk);
    @(negedge clk);
    chk(txd == ((exp_w[0] >> (slen-1)) & 1) && sclk, "R5", txd, (exp_w[0] >> (slen-1)) & 1);
  end

  always @(posedge sclk) if (rst_n && !fss_n) begin
    bitn++;
    if (bitn < slen) rxd <= sw[slen-1-bitn];
  end

  always @(negedge sclk) if (rst_n && !fss_n) begin
    got = {got[14:0], txd};
    nfall++;
    if (nfall == 1) first_fall = cyc;
    last_fall = cyc;
  end

  always @(posedge fss_n) if (rst_n && inframe) begin
    inframe = 0;
    had_rise = 1;
    rise_cyc = cyc;
    chk(nfall == exp_len[0], "R7 count", nfall, exp_len[0]);
    chk(int'(got) == (exp_w[0] & msk(exp_len[0])), "R7/R8 data", got, exp_w[0] & msk(exp_len[0]));
    chk(first_fall - fall_cyc == 2*H, "R6", first_fall - fall_cyc, 2*H);
    chk(rise_cyc - last_fall == 2*H, "R9 tail", rise_cyc - last_fall, 2*H);
    chk(rise_cyc - fall_cyc == (2*exp_len[0]+2)*H, "R9 length", rise_cyc - fall_cyc, (2*exp_len[0]+2)*H);
    void'(exp_w.pop_front());
    void'(exp_len.pop_front());
  end

  always @(negedge clk) if (rst_n) begin
    if (rx_valid) begin
      int e;
      e = rx_exp.size() > 0 ? rx_exp.pop_front() : -1;
      chk(int'(rx_data) == e, "R11 data", rx_data, e);
      chk(cyc == last_fall, "R11 timing", cyc, last_fall);
    end
    if (clk_oe_n !== 1'b0) chk(0, "R2", clk_oe_n, 0);
    if (data_oe_n && !(sclk && fss_n && !txd)) chk(0, "R1", {sclk, fss_n, txd}, 3'b110);
  end

  task automatic send(int d, int l);
    @(negedge clk);
    tx_data = 16'(d);
    word_len = 5'(l);
    tx_valid = 1;
    #1;
    while (!tx_ready) @(negedge clk);
    exp_w.push_back(d);
    exp_len.push_back(eff(l));
    @(posedge clk);
  endtask

  task automatic drop();
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic drain();
    while (exp_w.size() > 0 || !fss_n) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    // R1 R2 reset state
    chk(sclk && fss_n && !txd && data_oe_n && !clk_oe_n && !rx_valid,
        "R1 reset", {sclk, fss_n, txd, data_oe_n, clk_oe_n}, 5'b11010);
    rst_n = 1;
    // R3 enable low blocks start
    tx_valid = 1;
    tx_data = 16'h00F0;
    begin
      bit started = 0;
      repeat (40) begin
        @(negedge clk);
        if (tx_ready || !fss_n) started = 1;
      end
      chk(!started, "R3 enable low", started, 0);
    end
    tx_valid = 0;
    enable = 1;
    // directed words
    send(16'hA5, 8);       drop(); drain();
    send(16'h9, 4);        drop(); drain();
    send(16'hC3E1, 16);    drop(); drain();
    // R8 clamp and ignored upper bits
    send(16'hFFF6, 2);     drop(); drain();
    send(16'h8001, 20);    drop(); drain();
    send(16'hF05A, 7);     drop(); drain();
    // R10 back-to-back
    gaps.delete();
    send(16'h3C, 6);
    send(16'h1234, 13);
    send(16'h5, 4);
    drop(); drain();
    chk(gaps.size() >= 2 && gaps[gaps.size()-1] == 2*H && gaps[gaps.size()-2] == 2*H,
        "R10 gap", gaps.size() > 0 ? gaps[gaps.size()-1] : -1, 2*H);
    // random mix
    for (int i = 0; i < 40; i++) begin
      send(int'($urandom & 16'hFFFF), int'($urandom_range(2, 18)));
      if ($urandom_range(0, 2) != 0) begin
        drop();
        repeat ($urandom_range(0, 30)) @(negedge clk);
      end
    end
    drop(); drain();
    chk(exp_w.size() == 0 && rx_exp.size() == 0, "R11 all returned", rx_exp.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule